// File: doc/BRIEF.md
# Program Counter Address Generator

This block holds the program counter of a five-step, multi-cycle RISC core and computes every new instruction address. The control section drives a PC write enable and a two-bit source select. In the fetch step it asks for a plain increment of one instruction word. In the execute step it can add a branch offset to the PC, which has already been incremented, when the branch condition is true. It can also load the PC from the first register operand, which serves both an indirect subroutine call and a return through the link register.

For a call, the address of the instruction that follows the call is kept in a dedicated return-address register in the same edge that the PC is loaded from the register operand. A small link sequencer then runs through three named states. In IDLE it waits for a capture. A capture moves it to FORWARD, the step in which the saved address is driven out to the result register and `ret_fwd` is high. It then moves to WRITEBACK, the step in which `link_we` asks for the link register write. After that it returns to IDLE, unless a new capture has arrived. A capture in any state moves the sequencer to FORWARD: the transitions are IDLE→FORWARD, FORWARD→FORWARD, WRITEBACK→FORWARD on capture, and FORWARD→WRITEBACK, WRITEBACK→IDLE, IDLE→IDLE without one. Instruction decode, the register file and memory are outside this block.

Top module: `pc_addr_gen`

## Requirements
- R1: After reset `pc` is 0, `ret_addr` is 0, and `ret_fwd` and `link_we` are both 0.
- R2: When `pc_we`=1 and `pc_sel`=2'b00 (increment), `pc` becomes `pc`+4 at the next rising edge.
- R3: While `pc_we`=0, `pc` keeps its value whatever `pc_sel`, `branch_taken`, `ra_value` and `branch_offset` are.
- R4: When `pc_we`=1, `pc_sel`=2'b01 (branch) and `branch_taken`=1, `pc` becomes `pc` + `branch_offset`, with bits [1:0] of the offset cleared. The offset is two's complement, so negative offsets move the PC backwards.
- R5: When `pc_we`=1, `pc_sel`=2'b01 and `branch_taken`=0, `pc` keeps its value.
- R6: When `pc_we`=1 and `pc_sel`=2'b10 (register), `pc` becomes `ra_value` with bits [1:0] cleared. This path serves both call and return, and `pc` bits [1:0] are always 0.
- R7: A capture happens when `pc_we`=1, `pc_sel`=2'b10 and `save_ret`=1. On a capture, `ret_addr` takes the value `pc` had before the edge. In every other case, including `save_ret`=1 with any other select or with `pc_we`=0, `ret_addr` holds its value.
- R8: `ret_fwd` is high for the cycle after a capture (FORWARD). `link_we` is high in the following cycle (WRITEBACK) unless a new capture moved the sequencer back to FORWARD. The two outputs are never high together.
- R9: `pc_sel`=2'b11 is reserved: with `pc_we`=1 it leaves `pc` unchanged.
- R10: Address arithmetic wraps modulo 2^32, so an increment from 32'hFFFF_FFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | PC write enable from control |
| pc_sel | input | 2 | PC source: 00 increment, 01 branch, 10 register, 11 reserved |
| save_ret | input | 1 | With register select, saves the old PC as the return address |
| branch_taken | input | 1 | Branch condition result from the ALU compare |
| branch_offset | input | 32 | Signed branch displacement in bytes |
| ra_value | input | 32 | First register operand (call target or link value) |
| pc | output | 32 | Current program counter |
| ret_addr | output | 32 | Saved return address |
| ret_fwd | output | 1 | Return address is to be forwarded to the result register this cycle |
| link_we | output | 1 | Link register write step |

## Verification
Every PC update and return-address capture appears on the outputs one rising edge after the inputs that request it. `ret_fwd` follows a capture by one edge, and `link_we` follows it by two. The bench drives inputs just after a falling edge and advances its behavioural model at the rising edge. It compares all four outputs at the next falling edge, so each result is checked in the first cycle it is due. Back-to-back captures and a capture during WRITEBACK test the restart of the link sequence.

// File: rtl/pc_addr_gen_pkg.sv
package pc_addr_gen_pkg;

    typedef enum logic [1:0] {
        PCSRC_INC    = 2'b00,
        PCSRC_BRANCH = 2'b01,
        PCSRC_REG    = 2'b10,
        PCSRC_RSVD   = 2'b11
    } pc_src_t;

    typedef enum logic [1:0] {
        LNK_IDLE      = 2'b00,
        LNK_FORWARD   = 2'b01,
        LNK_WRITEBACK = 2'b10
    } link_state_t;

endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_addr_gen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [1:0]        src_sel,
    input  logic              taken,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] reg_target,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int               LOW_BITS   = $clog2(STEP);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << LOW_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] STEP_V     = ADDR_W'(STEP);

    pc_src_t src;

    always_comb begin
        src = pc_src_t'(src_sel);
        unique case (src)
            PCSRC_INC:    next_pc = cur_pc + STEP_V;
            PCSRC_BRANCH: next_pc = taken ? (cur_pc + (offset & ALIGN_MASK)) : cur_pc;
            PCSRC_REG:    next_pc = reg_target & ALIGN_MASK;
            PCSRC_RSVD:   next_pc = cur_pc;
            default:      next_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/link_sequencer.sv
module link_sequencer
    import pc_addr_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    output logic fwd,
    output logic wr
);
    link_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LNK_IDLE:      state_nx = capture ? LNK_FORWARD : LNK_IDLE;
            LNK_FORWARD:   state_nx = capture ? LNK_FORWARD : LNK_WRITEBACK;
            LNK_WRITEBACK: state_nx = capture ? LNK_FORWARD : LNK_IDLE;
            default:       state_nx = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LNK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        fwd = 1'b0;
        wr  = 1'b0;
        unique case (state)
            LNK_IDLE:      ;
            LNK_FORWARD:   fwd = 1'b1;
            LNK_WRITEBACK: wr  = 1'b1;
            default:       ;
        endcase
    end

    assert_fwd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && !capture) |=> wr);
    assert_capture_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> fwd);
    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd, wr}));

endmodule

// File: rtl/pc_addr_gen.sv
module pc_addr_gen
    import pc_addr_gen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_we,
    input  logic [1:0]        pc_sel,
    input  logic              save_ret,
    input  logic              branch_taken,
    input  logic [ADDR_W-1:0] branch_offset,
    input  logic [ADDR_W-1:0] ra_value,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_fwd,
    output logic              link_we
);
    localparam int LOW_BITS = $clog2(STEP);

    logic [ADDR_W-1:0] pc_q, ret_q, pc_nx;
    logic              capture;

    pc_next_calc #(.ADDR_W(ADDR_W), .STEP(STEP)) u_calc (
        .cur_pc     (pc_q),
        .src_sel    (pc_sel),
        .taken      (branch_taken),
        .offset     (branch_offset),
        .reg_target (ra_value),
        .next_pc    (pc_nx)
    );

    assign capture = pc_we && (pc_sel == PCSRC_REG) && save_ret;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ret_q <= '0;
        else if (capture) ret_q <= pc_q;
    end

    link_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .fwd     (ret_fwd),
        .wr      (link_we)
    );

    assign pc       = pc_q;
    assign ret_addr = ret_q;

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc));
    assert_pc_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel == PCSRC_INC) |=> (pc == $past(pc) + ADDR_W'(STEP)));
    assert_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_sel == PCSRC_BRANCH && !branch_taken) |=> $stable(pc));
    assert_ret_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(ret_addr));
    assert_ret_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ret_addr == $past(pc)));
    always_comb begin
        if (rst_n) assert_aligned_R6: assert (pc[LOW_BITS-1:0] == '0);
    end

endmodule

// File: tb/pc_addr_gen_bench.sv
module pc_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_we = 1'b0;
    logic [1:0]  pc_sel = 2'b00;
    logic        save_ret = 1'b0;
    logic        branch_taken = 1'b0;
    logic [31:0] branch_offset = '0;
    logic [31:0] ra_value = '0;
    logic [31:0] pc, ret_addr;
    logic        ret_fwd, link_we;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_pc = '0;
    logic [31:0] m_ret = '0;
    int          m_link = 0;

    always #4 clk = ~clk;

    pc_addr_gen u_pc_addr_gen (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_sel(pc_sel),
        .save_ret(save_ret), .branch_taken(branch_taken),
        .branch_offset(branch_offset), .ra_value(ra_value),
        .pc(pc), .ret_addr(ret_addr), .ret_fwd(ret_fwd), .link_we(link_we)
    );

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check32(tag, "pc", pc, m_pc);
        check32(tag, "ret_addr", ret_addr, m_ret);
        check32(tag, "ret_fwd", {31'b0, ret_fwd}, {31'b0, m_link == 1});
        check32(tag, "link_we", {31'b0, link_we}, {31'b0, m_link == 2});
    endtask

    task automatic step(string tag, logic we, logic [1:0] sel, logic sv,
                        logic tk, logic [31:0] off, logic [31:0] ra);
        bit cap;
        pc_we = we; pc_sel = sel; save_ret = sv; branch_taken = tk;
        branch_offset = off; ra_value = ra;
        @(posedge clk);
        cap = we && sel == 2'b10 && sv;
        if (cap) m_ret = m_pc;
        if (cap) m_link = 1;
        else if (m_link == 1) m_link = 2;
        else m_link = 0;
        if (we) begin
            case (sel)
                2'b00: m_pc = m_pc + 32'd4;
                2'b01: if (tk) m_pc = m_pc + (off & 32'hFFFF_FFFC);
                2'b10: m_pc = ra & 32'hFFFF_FFFC;
                default: ;
            endcase
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        step("R2", 1, 2'b00, 0, 0, 0, 0);
        step("R2", 1, 2'b00, 0, 0, 0, 0);
        step("R3", 0, 2'b00, 0, 1, 32'h40, 32'h100);
        step("R3", 0, 2'b10, 1, 1, 32'h40, 32'h104);
        step("R3", 0, 2'b01, 0, 1, 32'h40, 0);
        step("R4", 1, 2'b01, 0, 1, 32'h20, 0);
        step("R4", 1, 2'b01, 0, 1, 32'hFFFF_FFF0, 0);
        step("R4", 1, 2'b01, 0, 1, 32'h0000_0013, 0);
        step("R5", 1, 2'b01, 0, 0, 32'h100, 0);
        step("R9", 1, 2'b11, 1, 1, 32'h100, 32'h200);
        step("R7", 1, 2'b00, 1, 0, 0, 32'h300);
        step("R6", 1, 2'b10, 1, 0, 0, 32'h1000_0003);
        step("R8", 1, 2'b00, 0, 0, 0, 0);
        step("R8", 1, 2'b00, 0, 0, 0, 0);
        step("R8", 0, 2'b00, 0, 0, 0, 0);
        step("R6", 1, 2'b10, 0, 0, 0, 32'h0000_0022);
        step("R8", 1, 2'b10, 1, 0, 0, 32'h0000_4000);
        step("R8", 1, 2'b10, 1, 0, 0, 32'h0000_5000);
        step("R8", 1, 2'b00, 0, 0, 0, 0);
        step("R8", 1, 2'b10, 1, 0, 0, 32'h0000_6000);
        step("R8", 0, 2'b00, 0, 0, 0, 0);
        step("R8", 0, 2'b00, 0, 0, 0, 0);
        step("R6", 1, 2'b10, 0, 0, 0, 32'hFFFF_FFFE);
        step("R10", 1, 2'b00, 0, 0, 0, 0);
        step("R10", 1, 2'b01, 0, 1, 32'hFFFF_FFF8, 0);
        step("R7", 0, 2'b10, 1, 0, 0, 32'h700);
        for (int i = 0; i < 8; i++)
            step("R2", 1, 2'b00, 0, 0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule